// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block is the host-facing front end of a serial-bus bridge. A host drives SPI in mode 3: the clock idles high and data is sampled on the rising edge. The host sends frames that open with an opcode byte. The block oversamples the SPI pins with the system clock, assembles bytes and decodes each frame. Payload bytes are written into an external 96-entry transmit buffer. Internal registers are written or read one per frame. On MISO the block returns receive-buffer contents or a register value. When a transaction frame is complete and valid, the block sends a one-cycle start request to the bus-master sequencer, carrying the kind of transaction, the target addresses and the byte counts.

A keyed three-byte frame puts the block to sleep. While asleep it answers no frames until the `wake` input pulses. Raising chip select ends any frame. A frame that is cut short starts nothing, and the next frame is parsed from its first bit.

Top module: `spi_cmd_frame_decoder`

## Requirements
- R1: Bytes are received MSB first on rising SCLK while chip select is low. MISO changes only after falling SCLK and is 1 for every bit that has nothing to return. After reset MISO is 1, `asleep` is 0 and no strobe is active.
- R2: Opcode 0x00 takes the frame order opcode, count N, target address, then N data bytes. The data go to transmit-buffer slots 0..N-1. After the last data byte one request pulses with kind 0, `txn_len1`=N, `txn_len2`=0 and `txn_addr1` = address byte bits 7:1. Bit 0 of the address byte is ignored.
- R3: Opcode 0x01 takes opcode, count N, then address. A kind-1 request pulses right after the address byte and no buffer write occurs. A further read command issues a new request even if the host has not fetched the earlier data.
- R4: Opcode 0x02 takes opcode, write count W, read count Rd, address, then W data bytes. The data go to slots 0..W-1. The request has kind 2, `txn_len1`=W and `txn_len2`=Rd.
- R5: Opcode 0x03 takes opcode, N1, N2, first address, N1 data bytes, second address, then N2 data bytes. The data fill slots 0..N1+N2-1 contiguously. The request has kind 3, and `txn_addr2` carries the second address byte's bits 7:1.
- R6: A count of 0 or above 96, or an N1+N2 above 96 for opcode 0x03, causes no buffer write and no request. A count of exactly 96 is accepted.
- R7: After opcode 0x06, successive bytes on MISO return receive-buffer slots 0, 1, 2 and so on. Every byte past slot 95 returns 0xFF.
- R8: Opcode 0x20 takes a register address and then a data byte. It produces exactly one `reg_we` strobe, carrying that address and data. Any later bytes in the frame are ignored.
- R9: Opcode 0x21 takes a register address. `reg_re` strobes once as soon as the address is decoded, and the next MISO byte is that register's value. Later bytes return 0xFF, so the address does not increment.
- R10: Opcode 0x30 followed by 0x5A and then 0xA5 pulses `pd_enter` and sets `asleep`. Any other key leaves the block awake.
- R11: While `asleep` is 1, frames produce no strobe, no request and no MISO data. A `wake` pulse clears `asleep`.
- R12: Chip select going high mid-frame or mid-byte discards the frame without a request. The next frame decodes from byte 0, bit 0.
- R13: An opcode outside the set above produces no strobe or request, and MISO returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| tx_we | output | 1 | Transmit-buffer write strobe |
| tx_waddr | output | 7 | Transmit-buffer slot |
| tx_wdata | output | 8 | Transmit-buffer data |
| rx_raddr | output | 7 | Receive-buffer slot being read |
| rx_rdata | input | 8 | Receive-buffer data, combinational from rx_raddr |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, combinational from reg_addr |
| txn_valid | output | 1 | One-cycle transaction start request |
| txn_kind | output | 2 | 0 write, 1 read, 2 read after write, 3 write after write |
| txn_addr1 | output | 7 | First target address |
| txn_addr2 | output | 7 | Second target address (equals first unless kind 3) |
| txn_len1 | output | 7 | First phase byte count |
| txn_len2 | output | 7 | Second phase byte count, 0 for single-phase kinds |
| pd_enter | output | 1 | Pulses when sleep is entered |
| wake | input | 1 | Clears sleep |
| asleep | output | 1 | Block ignores SPI frames |

## Verification
The assertions assume the SPI clock half period spans at least four system clocks, so that a byte's decode and any MISO reload settle before the next falling SCLK. They also assume chip select changes only while SCLK is high. The stimulus holds each SCLK level for eight system clocks, lowers and raises chip select with SCLK high, and drives every pin on the falling system-clock edge. It mixes random transaction frames, whose counts stay inside the legal range, with directed frames at the count limits, short frames, wrong keys and sleep.

// File: rtl/spi_cmd_frame_decoder.sv
module spi_cmd_frame_decoder #(
  parameter int DEPTH = 96,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          tx_we,
  output logic [AW-1:0] tx_waddr,
  output logic [7:0]    tx_wdata,
  output logic [AW-1:0] rx_raddr,
  input  logic [7:0]    rx_rdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [7:0]    reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  output logic          txn_valid,
  output logic [1:0]    txn_kind,
  output logic [6:0]    txn_addr1,
  output logic [6:0]    txn_addr2,
  output logic [AW-1:0] txn_len1,
  output logic [AW-1:0] txn_len2,
  output logic          pd_enter,
  input  logic          wake,
  output logic          asleep
);

  localparam logic [7:0] OP_WR   = 8'h00;
  localparam logic [7:0] OP_RD   = 8'h01;
  localparam logic [7:0] OP_RAW  = 8'h02;
  localparam logic [7:0] OP_WAW  = 8'h03;
  localparam logic [7:0] OP_RBUF = 8'h06;
  localparam logic [7:0] OP_RWR  = 8'h20;
  localparam logic [7:0] OP_RRD  = 8'h21;
  localparam logic [7:0] OP_PD   = 8'h30;
  localparam logic [7:0] KEY1    = 8'h5A;
  localparam logic [7:0] KEY2    = 8'hA5;
  localparam logic [8:0] DEPTH9  = 9'(DEPTH);

  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= 3'b111;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  logic sck_rise, sck_fall, sel, sel_start;
  assign sck_rise  = sck_q[1] & ~sck_q[2];
  assign sck_fall  = ~sck_q[1] & sck_q[2];
  assign sel       = ~cs_q[1];
  assign sel_start = ~cs_q[1] & cs_q[2];

  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  logic       byte_stb;
  logic [7:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      sh_in    <= '0;
      byte_stb <= 1'b0;
      rx_byte  <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (!sel) bit_cnt <= '0;
      else if (sck_rise) begin
        sh_in   <= {sh_in[5:0], mosi_q[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_stb <= 1'b1;
          rx_byte  <= {sh_in, mosi_q[1]};
        end
      end
    end

  logic [7:0] idx, opc, cnt1, cnt2, rd_ptr, tx_sh;
  logic [6:0] a1, a2;
  logic       key_bad, dead, rd_pend, fresh;

  logic       take, two_cnt, is_txn, cnt_ok, last_byte, fire, in_data1, in_data2, wr_now;
  logic [7:0] hdr, k, k2, rd_val;

  assign take     = byte_stb & sel & ~dead & ~asleep;
  assign two_cnt  = (opc == OP_RAW) || (opc == OP_WAW);
  assign is_txn   = (opc[7:2] == 6'd0);
  assign hdr      = two_cnt ? 8'd3 : 8'd2;
  assign k        = idx - hdr - 8'd1;
  assign k2       = k - cnt1 - 8'd1;
  assign cnt_ok   = (cnt1 != 8'd0) && ({1'b0, cnt1} <= DEPTH9)
                 && (!two_cnt || ((cnt2 != 8'd0) && ({1'b0, cnt2} <= DEPTH9)))
                 && ((opc != OP_WAW) || (({1'b0, cnt1} + {1'b0, cnt2}) <= DEPTH9));
  assign in_data1 = k < cnt1;
  assign in_data2 = (opc == OP_WAW) && (k > cnt1) && (k2 < cnt2);
  assign last_byte = (opc == OP_RD)  ? (idx == hdr)
                   : (opc == OP_WAW) ? ((idx > hdr) && (k == cnt1 + cnt2))
                   :                   ((idx > hdr) && (k == cnt1 - 8'd1));
  assign fire     = take && is_txn && cnt_ok && (idx != 8'd0) && last_byte;
  assign wr_now   = take && is_txn && (opc != OP_RD) && cnt_ok && (idx > hdr)
                 && (in_data1 || in_data2);
  assign rd_val   = ({1'b0, rd_ptr} < DEPTH9) ? rx_rdata : 8'hFF;
  assign rx_raddr = rd_ptr[AW-1:0];
  assign reg_re   = rd_pend;
  assign spi_miso = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx <= '0; opc <= 8'hFF; cnt1 <= '0; cnt2 <= '0; rd_ptr <= '0;
      a1 <= '0; a2 <= '0; key_bad <= 1'b0; dead <= 1'b0; rd_pend <= 1'b0;
      tx_sh <= 8'hFF; fresh <= 1'b1; asleep <= 1'b0; pd_enter <= 1'b0;
      reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      tx_we <= 1'b0; tx_waddr <= '0; tx_wdata <= '0;
    end else begin
      tx_we    <= 1'b0;
      reg_we   <= 1'b0;
      pd_enter <= 1'b0;
      rd_pend  <= 1'b0;
      if (wake) asleep <= 1'b0;

      if (!sel) begin
        idx <= '0; opc <= 8'hFF; key_bad <= 1'b0; rd_ptr <= '0;
      end
      if (sel_start) begin
        tx_sh <= 8'hFF; fresh <= 1'b1; dead <= asleep;
      end else if (sel && sck_fall) begin
        if (fresh) fresh <= 1'b0;
        else       tx_sh <= {tx_sh[6:0], 1'b1};
      end
      if (rd_pend) begin
        tx_sh <= reg_rdata; fresh <= 1'b1;
      end

      if (wr_now) begin
        tx_we    <= 1'b1;
        tx_wdata <= rx_byte;
        tx_waddr <= in_data1 ? k[AW-1:0] : (k[AW-1:0] - 1'b1);
      end

      if (take) begin
        if (idx != 8'hFF) idx <= idx + 8'd1;
        if (idx == 8'd0) begin
          opc <= rx_byte;
          if (rx_byte == OP_RBUF) begin
            tx_sh <= rd_val; fresh <= 1'b1; rd_ptr <= 8'd1;
          end
        end else begin
          case (opc)
            OP_RBUF: begin
              tx_sh <= rd_val; fresh <= 1'b1;
              if (rd_ptr != 8'hFF) rd_ptr <= rd_ptr + 8'd1;
            end
            OP_RWR: begin
              if (idx == 8'd1) reg_addr <= rx_byte;
              else if (idx == 8'd2) begin
                reg_we <= 1'b1; reg_wdata <= rx_byte;
              end
            end
            OP_RRD: begin
              if (idx == 8'd1) begin
                reg_addr <= rx_byte; rd_pend <= 1'b1;
              end
            end
            OP_PD: begin
              if (idx == 8'd1) key_bad <= (rx_byte != KEY1);
              else if (idx == 8'd2 && !key_bad && rx_byte == KEY2) begin
                asleep <= 1'b1; pd_enter <= 1'b1;
              end
            end
            OP_WR, OP_RD, OP_RAW, OP_WAW: begin
              if (idx == 8'd1) cnt1 <= rx_byte;
              else if (idx == 8'd2 && two_cnt) cnt2 <= rx_byte;
              else if (idx == hdr) a1 <= rx_byte[7:1];
              else if (opc == OP_WAW && k == cnt1) a2 <= rx_byte[7:1];
            end
            default: ;
          endcase
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txn_valid <= 1'b0; txn_kind <= '0; txn_addr1 <= '0; txn_addr2 <= '0;
      txn_len1 <= '0; txn_len2 <= '0;
    end else begin
      txn_valid <= fire;
      if (fire) begin
        txn_kind  <= opc[1:0];
        txn_addr1 <= (opc == OP_RD) ? rx_byte[7:1] : a1;
        txn_addr2 <= (opc == OP_WAW) ? a2 : ((opc == OP_RD) ? rx_byte[7:1] : a1);
        txn_len1  <= cnt1[AW-1:0];
        txn_len2  <= two_cnt ? cnt2[AW-1:0] : '0;
      end
    end

endmodule

// File: rtl/spi_cmd_frame_decoder_chk.sv
module spi_cmd_frame_decoder_chk #(
  parameter int DEPTH = 96,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          tx_we,
  input logic [AW-1:0] tx_waddr,
  input logic          txn_valid,
  input logic          reg_we,
  input logic          reg_re,
  input logic          pd_enter,
  input logic          asleep
);

  a_r6_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |-> (int'(tx_waddr) < DEPTH));

  a_r11_no_request_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !asleep);

  a_r10_sleep_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> pd_enter);

  a_r9_single_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_we | txn_valid, reg_we, reg_re, pd_enter}));

  a_r12_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> !(tx_we || txn_valid || reg_we || pd_enter));

endmodule

bind spi_cmd_frame_decoder spi_cmd_frame_decoder_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/spi_cmd_frame_decoder_test.sv
module spi_cmd_frame_decoder_test;
  localparam int HP = 8;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0, wake = 1'b0;
  logic spi_miso, tx_we, reg_we, reg_re, txn_valid, pd_enter, asleep;
  logic [6:0] tx_waddr, rx_raddr, txn_addr1, txn_addr2, txn_len1, txn_len2;
  logic [7:0] tx_wdata, rx_rdata, reg_addr, reg_wdata, reg_rdata;
  logic [1:0] txn_kind;

  logic [7:0] txmem [0:95];
  logic [7:0] rxmem [0:95];
  logic [7:0] regs  [0:255];
  int n_txwr = 0, n_txn = 0, n_regwe = 0, n_regre = 0, n_pd = 0;
  int n_chk = 0, n_err = 0;
  logic [1:0] l_kind;
  logic [6:0] l_a1, l_a2, l_len1, l_len2;

  always #2 clk = ~clk;

  spi_cmd_frame_decoder uut (.*);

  assign rx_rdata  = (rx_raddr < 7'd96) ? rxmem[rx_raddr] : 8'h00;
  assign reg_rdata = regs[reg_addr];

  always @(negedge clk) begin
    if (tx_we) begin txmem[tx_waddr] = tx_wdata; n_txwr++; end
    if (reg_we) begin regs[reg_addr] = reg_wdata; n_regwe++; end
    if (reg_re) n_regre++;
    if (pd_enter) n_pd++;
    if (txn_valid) begin
      n_txn++; l_kind = txn_kind; l_a1 = txn_addr1; l_a2 = txn_addr2;
      l_len1 = txn_len1; l_len2 = txn_len2;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic bit txn_ok(input logic [7:0] op, input int n1, input int n2);
    bit ok = (n1 >= 1 && n1 <= 96);
    if (op >= 8'd2) ok = ok && (n2 >= 1 && n2 <= 96);
    if (op == 8'd3) ok = ok && (n1 + n2 <= 96);
    return ok;
  endfunction

  task automatic spi_frame(input bq_t f, output bq_t r);
    r = {};
    spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    foreach (f[i]) begin
      logic [7:0] v;
      v = '0;
      for (int b = 7; b >= 0; b--) begin
        spi_sclk = 1'b0; spi_mosi = f[i][b];
        repeat (HP) @(negedge clk);
        spi_sclk = 1'b1; v[b] = spi_miso;
        repeat (HP) @(negedge clk);
      end
      r.push_back(v);
    end
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic run_txn(input logic [7:0] op, input int n1, input int n2);
    bq_t f, r;
    logic [7:0] ab1, ab2, d;
    logic [7:0] expd [0:95];
    int nd, b_txn, b_wr, mism;
    bit ok;
    string tag;
    ab1 = 8'($urandom); ab2 = 8'($urandom);
    ok = txn_ok(op, n1, n2);
    tag = !ok ? "R6" : (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
    for (int i = 0; i < 96; i++) begin txmem[i] = 8'hEE; expd[i] = 8'hEE; end
    f.push_back(op); f.push_back(8'(n1));
    if (op >= 8'd2) f.push_back(8'(n2));
    f.push_back(ab1);
    nd = 0;
    if (op != 8'd1) begin
      for (int i = 0; i < (ok ? n1 : 2); i++) begin
        d = 8'($urandom); f.push_back(d);
        if (ok) begin expd[nd] = d; nd++; end
      end
      if (op == 8'd3) begin
        f.push_back(ab2);
        for (int i = 0; i < (ok ? n2 : 2); i++) begin
          d = 8'($urandom); f.push_back(d);
          if (ok) begin expd[nd] = d; nd++; end
        end
      end
    end
    b_txn = n_txn; b_wr = n_txwr;
    spi_frame(f, r);
    if (ok) begin
      chk({tag, " request count"}, n_txn - b_txn, 1);
      chk({tag, " kind"}, l_kind, op[1:0]);
      chk({tag, " addr1 bit0 ignored"}, l_a1, ab1[7:1]);
      chk({tag, " addr2"}, l_a2, (op == 8'd3) ? ab2[7:1] : ab1[7:1]);
      chk({tag, " len1"}, l_len1, n1);
      chk({tag, " len2"}, l_len2, (op >= 8'd2) ? n2 : 0);
      chk({tag, " buffer writes"}, n_txwr - b_wr, nd);
      mism = 0;
      for (int i = 0; i < nd; i++) if (txmem[i] !== expd[i]) mism++;
      chk({tag, " buffer contents"}, mism, 0);
    end else begin
      chk("R6 rejected count no request", n_txn - b_txn, 0);
      chk("R6 rejected count no write", n_txwr - b_wr, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    bq_t f, r;
    int b0, b1, b2, mism;
    logic [7:0] ra;
    b0 = $urandom(32'd20240611);
    for (int i = 0; i < 96; i++) rxmem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) regs[i] = 8'($urandom) & 8'h7F;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R1 reset miso idle", spi_miso, 1);
    chk("R1 reset awake", asleep, 0);
    chk("R1 reset no request", n_txn, 0);

    run_txn(8'h00, 96, 0);
    run_txn(8'h01, 96, 0);
    run_txn(8'h01, 1, 0);
    run_txn(8'h01, 5, 0);
    run_txn(8'h02, 5, 7);
    run_txn(8'h03, 40, 56);
    run_txn(8'h00, 0, 0);
    run_txn(8'h01, 97, 0);
    run_txn(8'h02, 3, 0);
    run_txn(8'h03, 50, 50);
    for (int it = 0; it < 16; it++)
      run_txn(8'($urandom_range(3, 0)), $urandom_range(12, 1), $urandom_range(12, 1));

    f = {8'h06, 8'h00, 8'h00, 8'h00, 8'h00};
    spi_frame(f, r);
    chk("R1 opcode byte returns FF", r[0], 8'hFF);
    mism = 0;
    for (int i = 1; i <= 4; i++) if (r[i] !== rxmem[i-1]) mism++;
    chk("R7 read buffer first slots", mism, 0);
    f = {8'h06};
    for (int i = 0; i < 98; i++) f.push_back(8'h00);
    spi_frame(f, r);
    chk("R7 last slot", r[96], rxmem[95]);
    chk("R7 past end", r[97], 8'hFF);
    chk("R7 past end again", r[98], 8'hFF);

    b0 = n_regwe;
    f = {8'h20, 8'h4C, 8'hB3, 8'h11};
    spi_frame(f, r);
    chk("R8 register written", regs[8'h4C], 8'hB3);
    chk("R8 single write strobe", n_regwe - b0, 1);
    chk("R8 extra byte ignored", regs[8'h4D] == 8'h11, 0);

    ra = 8'h4C;
    b0 = n_regre;
    f = {8'h21, ra, 8'h00, 8'h00};
    spi_frame(f, r);
    chk("R9 register value", r[2], regs[ra]);
    chk("R9 no increment", r[3], 8'hFF);
    chk("R9 one read strobe", n_regre - b0, 1);

    b0 = n_txn; b1 = n_txwr; b2 = n_regwe + n_regre + n_pd;
    f = {8'h55, 8'h01, 8'h02, 8'h03};
    spi_frame(f, r);
    chk("R13 unknown opcode no action", (n_txn - b0) + (n_txwr - b1) + (n_regwe + n_regre + n_pd - b2), 0);
    chk("R13 unknown opcode miso", {r[1], r[2], r[3]}, 24'hFFFFFF);

    b0 = n_txn;
    f = {8'h00, 8'h04, 8'h20, 8'h01, 8'h02};
    spi_frame(f, r);
    chk("R12 short frame no request", n_txn - b0, 0);
    spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      spi_sclk = 1'b0; spi_mosi = 1'b1; repeat (HP) @(negedge clk);
      spi_sclk = 1'b1; repeat (HP) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (3 * HP) @(negedge clk);
    f = {8'h00, 8'h02, 8'h6B, 8'hC1, 8'hC2};
    spi_frame(f, r);
    chk("R12 resync request", n_txn - b0, 1);
    chk("R12 resync addr", l_a1, 7'h35);
    chk("R12 resync data", {txmem[0], txmem[1]}, 16'hC1C2);

    b0 = n_pd;
    f = {8'h30, 8'h5A, 8'h5B};
    spi_frame(f, r);
    chk("R10 wrong second key", asleep, 0);
    f = {8'h30, 8'hA5, 8'h5A};
    spi_frame(f, r);
    chk("R10 swapped keys", asleep, 0);
    chk("R10 no entry pulse", n_pd - b0, 0);
    f = {8'h30, 8'h5A, 8'hA5};
    spi_frame(f, r);
    chk("R10 asleep after key", asleep, 1);
    chk("R10 entry pulse", n_pd - b0, 1);

    b0 = n_txn; b1 = n_regre;
    f = {8'h00, 8'h02, 8'h10, 8'h01, 8'h02};
    spi_frame(f, r);
    chk("R11 no request asleep", n_txn - b0, 0);
    f = {8'h21, ra, 8'h00};
    spi_frame(f, r);
    chk("R11 no register read asleep", n_regre - b1, 0);
    chk("R11 miso silent asleep", r[2], 8'hFF);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 wake clears", asleep, 0);
    run_txn(8'h01, 9, 0);

    finish_up();
  end
endmodule